// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block is the bypass and interlock control for a five-stage in-order integer pipeline with fetch, decode and register read, execute, memory access and writeback stages. It looks at the register numbers, write-enables and load/store flags held in the decode stage and in the three pipeline registers behind it. From these it chooses where every operand comes from. The execute stage takes its two operands from the register-read value, the execute/memory register or the memory/writeback register. The branch comparator in decode takes its operands from the register read or from the execute/memory register. The store data in the memory stage takes either the value carried along with the store or a load result that is just retiring.

When no bypass can deliver a value in time, the block raises a stall, which holds fetch and decode, and a bubble, which injects an empty slot into execute. It does this for two cases: an execute-stage consumer that directly follows a load, and a decode-stage branch whose source is still being computed or loaded. The register file writes in the first half of a cycle and reads in the second, so a writeback and a read of the same register in one cycle need no bypass. The operand multiplexers sit in the same module, so the bypassed values can be observed directly.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Register 0 is never a bypass source and never causes a stall. A producer whose destination is 0 is ignored.
- R2: Execute operand select encoding is 2'b00 register read, 2'b01 execute/memory result and 2'b10 memory/writeback value; 2'b11 never appears. 2'b01 is chosen when the execute/memory instruction writes the operand's register and is not a load.
- R3: 2'b10 is chosen when the memory/writeback instruction writes the operand's register and the execute/memory instruction does not write that register.
- R4: The youngest producer wins. When the execute/memory instruction writes the register, the memory/writeback stage is never chosen, even if it also matches. If that younger producer is a load, the select is 2'b00.
- R5: A branch operand select is 1 (execute/memory result) when the execute/memory instruction writes that register and is not a load; otherwise it is 0 (register read, which already sees a same-cycle writeback).
- R6: Store data select is 1 (memory/writeback value) when the execute/memory instruction is a store, the memory/writeback instruction is a writing load, and the load's destination equals the store's data register; otherwise it is 0.
- R7: When the decode instruction uses a register that the load in execute writes, the stall and bubble outputs go high together for that cycle. Store data in the second source is the exception.
- R8: A load followed directly by a store whose only dependence is its data register causes no stall.
- R9: A branch in decode stalls while any writing instruction in execute targets one of the registers the branch uses.
- R10: A branch in decode also stalls while a writing load in the memory stage targets one of its used registers.
- R11: Each operand output equals the source named by its select.
- R12: Outside the cases of R7, R9 and R10, stall and bubble stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RW | decode first source register |
| id_rs2 | input | RW | decode second source register |
| id_rs1_used | input | 1 | decode instruction reads rs1 |
| id_rs2_used | input | 1 | decode instruction reads rs2 |
| id_branch | input | 1 | decode instruction is a branch compared in decode |
| id_store | input | 1 | decode instruction is a store (rs2 is its data) |
| id_a | input | XLEN | register read value for rs1 in decode |
| id_b | input | XLEN | register read value for rs2 in decode |
| ide_rs1 | input | RW | execute-stage first source |
| ide_rs2 | input | RW | execute-stage second source |
| ide_rd | input | RW | execute-stage destination |
| ide_we | input | 1 | execute-stage instruction writes a register |
| ide_load | input | 1 | execute-stage instruction is a load |
| ide_a | input | XLEN | latched register value for execute rs1 |
| ide_b | input | XLEN | latched register value for execute rs2 |
| exm_rd | input | RW | memory-stage destination |
| exm_we | input | 1 | memory-stage instruction writes a register |
| exm_load | input | 1 | memory-stage instruction is a load |
| exm_store | input | 1 | memory-stage instruction is a store |
| exm_rs2 | input | RW | memory-stage store data register |
| exm_result | input | XLEN | execute result held after execute |
| exm_sdata | input | XLEN | store data carried with the store |
| wb_rd | input | RW | writeback destination |
| wb_we | input | 1 | writeback instruction writes a register |
| wb_load | input | 1 | writeback instruction is a load |
| wb_value | input | XLEN | value being written back |
| sel_ex_a | output | 2 | execute operand A source |
| sel_ex_b | output | 2 | execute operand B source |
| sel_br_a | output | 1 | branch operand A source |
| sel_br_b | output | 1 | branch operand B source |
| sel_st | output | 1 | store data source |
| ex_op_a | output | XLEN | bypassed execute operand A |
| ex_op_b | output | XLEN | bypassed execute operand B |
| br_op_a | output | XLEN | bypassed branch operand A |
| br_op_b | output | XLEN | bypassed branch operand B |
| st_data | output | XLEN | bypassed store data |
| stall | output | 1 | hold fetch and decode |
| bubble | output | 1 | inject an empty slot into execute |

## Verification
The hardest situations to reach are those where several stages name the same register at once. Examples are an execute/memory load and a memory/writeback writer targeting the same operand, or a store whose data register matches a retiring load while a branch in decode also matches the execute-stage destination. The stimulus draws every register number from a small pool that includes register 0, so these collisions occur in most cycles. Directed cases before the random run pin down each priority and stall rule on its own.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic [RW-1:0]   id_rs1,
  input  logic [RW-1:0]   id_rs2,
  input  logic            id_rs1_used,
  input  logic            id_rs2_used,
  input  logic            id_branch,
  input  logic            id_store,
  input  logic [XLEN-1:0] id_a,
  input  logic [XLEN-1:0] id_b,
  input  logic [RW-1:0]   ide_rs1,
  input  logic [RW-1:0]   ide_rs2,
  input  logic [RW-1:0]   ide_rd,
  input  logic            ide_we,
  input  logic            ide_load,
  input  logic [XLEN-1:0] ide_a,
  input  logic [XLEN-1:0] ide_b,
  input  logic [RW-1:0]   exm_rd,
  input  logic            exm_we,
  input  logic            exm_load,
  input  logic            exm_store,
  input  logic [RW-1:0]   exm_rs2,
  input  logic [XLEN-1:0] exm_result,
  input  logic [XLEN-1:0] exm_sdata,
  input  logic [RW-1:0]   wb_rd,
  input  logic            wb_we,
  input  logic            wb_load,
  input  logic [XLEN-1:0] wb_value,
  output logic [1:0]      sel_ex_a,
  output logic [1:0]      sel_ex_b,
  output logic            sel_br_a,
  output logic            sel_br_b,
  output logic            sel_st,
  output logic [XLEN-1:0] ex_op_a,
  output logic [XLEN-1:0] ex_op_b,
  output logic [XLEN-1:0] br_op_a,
  output logic [XLEN-1:0] br_op_b,
  output logic [XLEN-1:0] st_data,
  output logic            stall,
  output logic            bubble
);

  localparam logic [1:0] SRC_RF  = 2'b00;
  localparam logic [1:0] SRC_EXM = 2'b01;
  localparam logic [1:0] SRC_WB  = 2'b10;

  function automatic logic writes(input logic we, input logic [RW-1:0] dst,
                                  input logic [RW-1:0] src);
    return we && (dst != '0) && (dst == src);
  endfunction

  function automatic logic [1:0] pick(input logic [RW-1:0] src);
    if (writes(exm_we, exm_rd, src))
      return exm_load ? SRC_RF : SRC_EXM;
    else if (writes(wb_we, wb_rd, src))
      return SRC_WB;
    else
      return SRC_RF;
  endfunction

  function automatic logic [XLEN-1:0] route(input logic [1:0] s,
                                            input logic [XLEN-1:0] rf);
    case (s)
      SRC_EXM: return exm_result;
      SRC_WB:  return wb_value;
      default: return rf;
    endcase
  endfunction

  assign sel_ex_a = pick(ide_rs1);
  assign sel_ex_b = pick(ide_rs2);
  assign ex_op_a  = route(sel_ex_a, ide_a);
  assign ex_op_b  = route(sel_ex_b, ide_b);

  assign sel_br_a = writes(exm_we, exm_rd, id_rs1) && !exm_load;
  assign sel_br_b = writes(exm_we, exm_rd, id_rs2) && !exm_load;
  assign br_op_a  = sel_br_a ? exm_result : id_a;
  assign br_op_b  = sel_br_b ? exm_result : id_b;

  assign sel_st  = exm_store && wb_load && writes(wb_we, wb_rd, exm_rs2);
  assign st_data = sel_st ? wb_value : exm_sdata;

  logic load_use, br_wait_a, br_wait_b;

  assign load_use = ide_load &&
                    ((id_rs1_used && writes(ide_we, ide_rd, id_rs1)) ||
                     (id_rs2_used && !id_store && writes(ide_we, ide_rd, id_rs2)));

  assign br_wait_a = id_rs1_used &&
                     (writes(ide_we, ide_rd, id_rs1) ||
                      (exm_load && writes(exm_we, exm_rd, id_rs1)));
  assign br_wait_b = id_rs2_used &&
                     (writes(ide_we, ide_rd, id_rs2) ||
                      (exm_load && writes(exm_we, exm_rd, id_rs2)));

  assign stall  = load_use || (id_branch && (br_wait_a || br_wait_b));
  assign bubble = stall;

endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input logic [RW-1:0]   id_rs1,
  input logic            id_rs1_used,
  input logic            id_branch,
  input logic            id_store,
  input logic [RW-1:0]   ide_rs1,
  input logic [RW-1:0]   ide_rs2,
  input logic [RW-1:0]   ide_rd,
  input logic            ide_we,
  input logic [RW-1:0]   exm_rd,
  input logic            exm_we,
  input logic            exm_load,
  input logic            exm_store,
  input logic [XLEN-1:0] exm_result,
  input logic [XLEN-1:0] wb_value,
  input logic [1:0]      sel_ex_a,
  input logic [1:0]      sel_ex_b,
  input logic            sel_br_a,
  input logic            sel_br_b,
  input logic            sel_st,
  input logic [XLEN-1:0] ex_op_a,
  input logic [XLEN-1:0] ex_op_b,
  input logic            stall,
  input logic            bubble
);

  always_comb begin
    AST_ZERO_REG_INERT: assert ((ide_rs1 != '0 || sel_ex_a == 2'b00) &&
                                (ide_rs2 != '0 || sel_ex_b == 2'b00)); // R1
    AST_SEL_LEGAL: assert (sel_ex_a != 2'b11 && sel_ex_b != 2'b11); // R2
    AST_EXM_VALUE: assert ((sel_ex_a != 2'b01 || ex_op_a == exm_result) &&
                           (sel_ex_b != 2'b01 || ex_op_b == exm_result)); // R11
    AST_WB_VALUE: assert ((sel_ex_a != 2'b10 || ex_op_a == wb_value) &&
                          (sel_ex_b != 2'b10 || ex_op_b == wb_value)); // R11
    AST_BR_NO_LOAD: assert (!exm_load || (!sel_br_a && !sel_br_b)); // R5
    AST_STORE_ONLY: assert (exm_store || !sel_st); // R6
    AST_BUBBLE_PAIR: assert (bubble == stall); // R7
    AST_STALL_HAS_PRODUCER: assert (!stall || (ide_we && ide_rd != '0) ||
                                    (exm_load && exm_we && exm_rd != '0)); // R12
    AST_PURE_STORE_NO_STALL: assert (!(id_store && !id_branch && !id_rs1_used) ||
                                     !stall); // R8
    AST_ZERO_NO_STALL_SRC: assert (!(id_rs1 == '0 && id_branch && id_rs1_used &&
                                     !id_store && ide_rd == '0 && exm_rd == '0) ||
                                   !stall); // R1
  end

endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (.*);

// File: tb/tb_fwd_hazard_unit.sv
module tb_fwd_hazard_unit;
  localparam int XLEN = 32;
  localparam int RW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] id_rs1, id_rs2, ide_rs1, ide_rs2, ide_rd, exm_rd, exm_rs2, wb_rd;
  logic id_rs1_used, id_rs2_used, id_branch, id_store;
  logic ide_we, ide_load, exm_we, exm_load, exm_store, wb_we, wb_load;
  logic [XLEN-1:0] id_a, id_b, ide_a, ide_b, exm_result, exm_sdata, wb_value;
  logic [1:0] sel_ex_a, sel_ex_b;
  logic sel_br_a, sel_br_b, sel_st, stall, bubble;
  logic [XLEN-1:0] ex_op_a, ex_op_b, br_op_a, br_op_b, st_data;

  fwd_hazard_unit #(.XLEN(XLEN), .NREGS(32)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit prod(input logic we, input logic [RW-1:0] d,
                              input logic [RW-1:0] s);
    return we && d != 0 && d == s;
  endfunction

  function automatic int m_ex_sel(input logic [RW-1:0] s);
    int r = 0;
    if (prod(exm_we, exm_rd, s)) r = exm_load ? 0 : 1;
    else if (prod(wb_we, wb_rd, s)) r = 2;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] m_ex_val(input int s, input logic [XLEN-1:0] rf);
    if (s == 1) return exm_result;
    if (s == 2) return wb_value;
    return rf;
  endfunction

  function automatic bit m_stall();
    bit lu, br;
    lu = ide_load && ((id_rs1_used && prod(ide_we, ide_rd, id_rs1)) ||
                      (id_rs2_used && !id_store && prod(ide_we, ide_rd, id_rs2)));
    br = 0;
    if (id_branch) begin
      if (id_rs1_used && (prod(ide_we, ide_rd, id_rs1) ||
                          (exm_load && prod(exm_we, exm_rd, id_rs1)))) br = 1;
      if (id_rs2_used && (prod(ide_we, ide_rd, id_rs2) ||
                          (exm_load && prod(exm_we, exm_rd, id_rs2)))) br = 1;
    end
    return lu || br;
  endfunction

  task automatic compare_all();
    int ea, eb;
    bit ba, bb, es, st;
    ea = m_ex_sel(ide_rs1);
    eb = m_ex_sel(ide_rs2);
    ba = prod(exm_we, exm_rd, id_rs1) && !exm_load;
    bb = prod(exm_we, exm_rd, id_rs2) && !exm_load;
    es = exm_store && wb_load && prod(wb_we, wb_rd, exm_rs2);
    st = m_stall();
    chk("R2/R3/R4", "sel_ex_a", 64'(sel_ex_a), 64'(ea));
    chk("R2/R3/R4", "sel_ex_b", 64'(sel_ex_b), 64'(eb));
    chk("R11", "ex_op_a", 64'(ex_op_a), 64'(m_ex_val(ea, ide_a)));
    chk("R11", "ex_op_b", 64'(ex_op_b), 64'(m_ex_val(eb, ide_b)));
    chk("R5", "sel_br_a", 64'(sel_br_a), 64'(ba));
    chk("R5", "sel_br_b", 64'(sel_br_b), 64'(bb));
    chk("R11", "br_op_a", 64'(br_op_a), 64'(ba ? exm_result : id_a));
    chk("R11", "br_op_b", 64'(br_op_b), 64'(bb ? exm_result : id_b));
    chk("R6", "sel_st", 64'(sel_st), 64'(es));
    chk("R11", "st_data", 64'(st_data), 64'(es ? wb_value : exm_sdata));
    chk("R7/R12", "stall", 64'(stall), 64'(st));
    chk("R7", "bubble", 64'(bubble), 64'(st));
  endtask

  task automatic idle();
    id_rs1 = 0; id_rs2 = 0; id_rs1_used = 0; id_rs2_used = 0;
    id_branch = 0; id_store = 0; id_a = 32'h1111; id_b = 32'h2222;
    ide_rs1 = 0; ide_rs2 = 0; ide_rd = 0; ide_we = 0; ide_load = 0;
    ide_a = 32'h3333; ide_b = 32'h4444;
    exm_rd = 0; exm_we = 0; exm_load = 0; exm_store = 0; exm_rs2 = 0;
    exm_result = 32'hE0E0; exm_sdata = 32'h5555;
    wb_rd = 0; wb_we = 0; wb_load = 0; wb_value = 32'hB0B0;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    @(posedge clk);
    #1;
  endtask

  initial begin
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    @(negedge clk);
    chk("R12", "reset stall", 64'(stall), 64'(0));
    chk("R2", "reset sel_ex_a", 64'(sel_ex_a), 64'(0));
    chk("R11", "reset ex_op_a", 64'(ex_op_a), 64'(32'h3333));
    @(posedge clk); #1;

    // R2: EX/MEM producer into execute A
    idle(); ide_rs1 = 5; exm_rd = 5; exm_we = 1;
    @(negedge clk); chk("R2", "exm->ex", 64'(sel_ex_a), 64'(1)); step();
    // R3: MEM/WB producer into execute B
    idle(); ide_rs2 = 6; wb_rd = 6; wb_we = 1;
    @(negedge clk); chk("R3", "wb->ex", 64'(ex_op_b), 64'(32'hB0B0)); step();
    // R4: both match, youngest wins
    idle(); ide_rs1 = 7; exm_rd = 7; exm_we = 1; wb_rd = 7; wb_we = 1;
    @(negedge clk); chk("R4", "youngest", 64'(sel_ex_a), 64'(1)); step();
    // R4: younger is load -> register read
    idle(); ide_rs1 = 7; exm_rd = 7; exm_we = 1; exm_load = 1; wb_rd = 7; wb_we = 1;
    @(negedge clk); chk("R4", "younger load", 64'(sel_ex_a), 64'(0)); step();
    // R1: register 0 ignored everywhere
    idle(); ide_rs1 = 0; exm_we = 1; wb_we = 1; ide_we = 1; ide_load = 1;
    id_rs1_used = 1; id_branch = 1;
    @(negedge clk);
    chk("R1", "r0 sel", 64'(sel_ex_a), 64'(0));
    chk("R1", "r0 stall", 64'(stall), 64'(0));
    step();
    // R5: branch bypass from EX/MEM
    idle(); id_branch = 1; id_rs2 = 9; id_rs2_used = 1; exm_rd = 9; exm_we = 1;
    @(negedge clk); chk("R5", "br fwd", 64'(br_op_b), 64'(32'hE0E0)); step();
    // R5: WB match uses register read
    idle(); id_branch = 1; id_rs1 = 9; id_rs1_used = 1; wb_rd = 9; wb_we = 1;
    @(negedge clk); chk("R5", "br wb", 64'(sel_br_a), 64'(0)); step();
    // R6: load then store
    idle(); exm_store = 1; exm_rs2 = 4; wb_load = 1; wb_we = 1; wb_rd = 4;
    @(negedge clk); chk("R6", "mem-mem", 64'(st_data), 64'(32'hB0B0)); step();
    // R7: load-use
    idle(); ide_load = 1; ide_we = 1; ide_rd = 3; id_rs2 = 3; id_rs2_used = 1;
    @(negedge clk);
    chk("R7", "load-use stall", 64'(stall), 64'(1));
    chk("R7", "load-use bubble", 64'(bubble), 64'(1));
    step();
    // R8: store data after load
    idle(); ide_load = 1; ide_we = 1; ide_rd = 3; id_rs2 = 3; id_rs2_used = 1;
    id_store = 1; id_rs1 = 2; id_rs1_used = 1;
    @(negedge clk); chk("R8", "store no stall", 64'(stall), 64'(0)); step();
    // R9: branch after ALU producer in execute
    idle(); id_branch = 1; id_rs1 = 8; id_rs1_used = 1; ide_we = 1; ide_rd = 8;
    @(negedge clk); chk("R9", "branch alu", 64'(stall), 64'(1)); step();
    // R10: branch after load in memory stage
    idle(); id_branch = 1; id_rs2 = 8; id_rs2_used = 1; exm_we = 1; exm_load = 1; exm_rd = 8;
    @(negedge clk); chk("R10", "branch load", 64'(stall), 64'(1)); step();
    // R12: ALU producer and ALU consumer: no stall
    idle(); id_rs1 = 8; id_rs1_used = 1; ide_we = 1; ide_rd = 8;
    @(negedge clk); chk("R12", "alu no stall", 64'(stall), 64'(0)); step();

    for (int i = 0; i < 4000; i++) begin
      id_rs1 = RW'($urandom % 4); id_rs2 = RW'($urandom % 4);
      ide_rs1 = RW'($urandom % 4); ide_rs2 = RW'($urandom % 4);
      ide_rd = RW'($urandom % 4); exm_rd = RW'($urandom % 4);
      exm_rs2 = RW'($urandom % 4); wb_rd = RW'($urandom % 4);
      {id_rs1_used, id_rs2_used, id_branch, id_store} = 4'($urandom);
      {ide_we, ide_load, exm_we, exm_load, exm_store, wb_we, wb_load} = 7'($urandom);
      id_a = $urandom; id_b = $urandom; ide_a = $urandom; ide_b = $urandom;
      exm_result = $urandom; exm_sdata = $urandom; wb_value = $urandom;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule